// File: doc/BRIEF.md
# Home Directory Coherence Controller

The memory-side home node of a directory-based invalidation protocol. For every line in a small address table it keeps the line's data and a directory entry. The directory entry has a mode and an N-bit vector. The mode is one of: readers, single writer, readers-while-invalidating, or writer-while-recalling. In the readers modes the vector is the set of sharers. In the writer modes the vector holds the one-hot owner. An empty readers-while-invalidating entry behaves exactly like an empty readers entry.

Each cycle the controller takes at most one action: a cache reply, the request at the head of the request queue, or a voluntary push of a shared copy. Replies are always consumed. A request is dequeued only when it can be answered. Otherwise the controller starts the recall or invalidation it needs and leaves the request at the head, where it is re-evaluated every cycle until the directory leaves its transient mode. Every outgoing message is registered and appears for one cycle, on the cycle after the action that produced it.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every line is in readers mode with an empty sharer set and zero data, and `out_valid_o` is low.
- R2: A shared request to a line in readers mode (or an empty transient-readers line) adds the requester to the set, is dequeued, and sends a shared reply (kind 0) with the line data to the requester only.
- R3: A shared request to a line held by a different writer moves the line to writer-while-recalling, sends a writeback request (kind 2) to that owner, and is not dequeued.
- R4: An exclusive request to a readers line whose set is empty or holds only the requester makes the requester the writer, is dequeued, and sends an exclusive reply (kind 1) with the line data.
- R5: An exclusive request to a readers line with other sharers moves the line to readers-while-invalidating with the requester removed, sends one invalidate request (kind 4) whose destination mask holds every other sharer, and is not dequeued.
- R6: An exclusive request to a line held by a different writer moves the line to writer-while-recalling and sends a flush request (kind 3) to that owner, without dequeue.
- R7: A request to a line in a non-empty readers-while-invalidating mode, in writer-while-recalling mode, or held in writer mode by the requester itself, is not dequeued and sends nothing.
- R8: An invalidate reply (reply kind 0) removes the sender from the set in either readers mode. Once the set empties, a held exclusive request is answered with an exclusive reply.
- R9: A writeback reply (reply kind 1) stores its data and leaves readers mode with the sender as sole sharer. A flush reply (reply kind 2) stores its data and leaves readers mode with an empty set.
- R10: In a cycle with a valid reply, the reply is consumed, no request is dequeued, and no message follows.
- R11: A push, taken only when neither a reply nor a request is valid, sends a shared reply and adds the target when the line is in readers mode without it. Otherwise it sends nothing.
- R12: Each message is valid for exactly the one cycle after its action. Directed messages carry a one-hot destination, and `out_addr_o` names the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request queue head present |
| req_excl_i | input | 1 | 1 = exclusive request, 0 = shared |
| req_id_i | input | ID_W | Requesting cache |
| req_addr_i | input | ADDR_W | Requested line |
| req_ready_o | output | 1 | Head request dequeued this cycle |
| rep_valid_i | input | 1 | Cache reply present (always consumed) |
| rep_kind_i | input | 2 | 0 invalidate, 1 writeback, 2 flush |
| rep_id_i | input | ID_W | Replying cache |
| rep_addr_i | input | ADDR_W | Line of the reply |
| rep_data_i | input | DATA_W | Data carried by writeback or flush |
| push_valid_i | input | 1 | Voluntary shared push |
| push_id_i | input | ID_W | Push target cache |
| push_addr_i | input | ADDR_W | Line to push |
| out_valid_o | output | 1 | Outgoing message valid |
| out_kind_o | output | 3 | 0 shared rep, 1 excl rep, 2 writeback req, 3 flush req, 4 invalidate req |
| out_dest_o | output | N | Destination cache mask |
| out_addr_o | output | ADDR_W | Line of the message |
| out_data_o | output | DATA_W | Line data (replies) |

## Verification
Directed sequences walk one line through every mode: sharing growth, invalidation fan-out and drain, a writeback recall and a flush recall. These show that writeback and flush leave different sharer sets and that a held request is answered once its replies land. Random traffic then mixes requests from all caches over all lines with replies aimed at the held line and fully random replies. It separates reply-over-request priority from stalling, and it separates ignored pushes from accepted ones. Every message's kind, mask, line and data is compared against a bench model of the directory.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {ST_R = 2'd0, ST_W = 2'd1, ST_TR = 2'd2, ST_TW = 2'd3} dir_mode_e;
  typedef enum logic [2:0] {
    MSG_SH_REP = 3'd0, MSG_EX_REP = 3'd1, MSG_WB_REQ = 3'd2,
    MSG_FL_REQ = 3'd3, MSG_INV_REQ = 3'd4
  } msg_kind_e;
  typedef enum logic [1:0] {REP_INV = 2'd0, REP_WB = 2'd1, REP_FL = 2'd2} rep_kind_e;
endpackage

// File: rtl/dir_table.sv
module dir_table
  import coh_pkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  dir_mode_e         wr_mode_i,
  input  logic [N-1:0]      wr_vec_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output dir_mode_e         rd_mode_o,
  output logic [N-1:0]      rd_vec_o,
  output logic [DATA_W-1:0] rd_data_o
);
  dir_mode_e         mode_q [DEPTH];
  logic [N-1:0]      vec_q  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mode_q[e] <= ST_R;
        vec_q[e]  <= '0;
        data_q[e] <= '0;
      end else if (wr_en_i && addr_i == ADDR_W'(e)) begin
        mode_q[e] <= wr_mode_i;
        vec_q[e]  <= wr_vec_i;
        data_q[e] <= wr_data_i;
      end
    end
  end

  assign rd_mode_o = mode_q[addr_i];
  assign rd_vec_o  = vec_q[addr_i];
  assign rd_data_o = data_q[addr_i];
endmodule

// File: rtl/dir_engine.sv
module dir_engine
  import coh_pkg::*;
#(
  parameter int N      = 4,
  parameter int DATA_W = 8,
  localparam int ID_W  = $clog2(N)
) (
  input  logic              rep_valid_i,
  input  rep_kind_e         rep_kind_i,
  input  logic [ID_W-1:0]   rep_id_i,
  input  logic [DATA_W-1:0] rep_data_i,
  input  logic              req_valid_i,
  input  logic              req_excl_i,
  input  logic [ID_W-1:0]   req_id_i,
  input  logic              push_valid_i,
  input  logic [ID_W-1:0]   push_id_i,
  input  dir_mode_e         cur_mode_i,
  input  logic [N-1:0]      cur_vec_i,
  input  logic [DATA_W-1:0] cur_data_i,
  output logic              wr_en_o,
  output dir_mode_e         nxt_mode_o,
  output logic [N-1:0]      nxt_vec_o,
  output logic [DATA_W-1:0] nxt_data_o,
  output logic              req_ready_o,
  output logic              msg_valid_o,
  output msg_kind_e         msg_kind_o,
  output logic [N-1:0]      msg_dest_o
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] rep_oh, req_oh, push_oh, others;
  dir_mode_e    eff_mode;

  assign rep_oh  = ONE << rep_id_i;
  assign req_oh  = ONE << req_id_i;
  assign push_oh = ONE << push_id_i;
  assign others  = cur_vec_i & ~req_oh;
  // an empty transient-readers entry is a plain readers entry
  assign eff_mode = (cur_mode_i == ST_TR && cur_vec_i == '0) ? ST_R : cur_mode_i;

  always_comb begin
    wr_en_o     = 1'b0;
    nxt_mode_o  = cur_mode_i;
    nxt_vec_o   = cur_vec_i;
    nxt_data_o  = cur_data_i;
    req_ready_o = 1'b0;
    msg_valid_o = 1'b0;
    msg_kind_o  = MSG_SH_REP;
    msg_dest_o  = '0;
    if (rep_valid_i) begin
      unique case (rep_kind_i)
        REP_INV: begin
          if (cur_mode_i == ST_R || cur_mode_i == ST_TR) begin
            wr_en_o   = 1'b1;
            nxt_vec_o = cur_vec_i & ~rep_oh;
          end
        end
        REP_WB: begin
          wr_en_o    = 1'b1;
          nxt_mode_o = ST_R;
          nxt_vec_o  = rep_oh;
          nxt_data_o = rep_data_i;
        end
        REP_FL: begin
          wr_en_o    = 1'b1;
          nxt_mode_o = ST_R;
          nxt_vec_o  = '0;
          nxt_data_o = rep_data_i;
        end
        default: ;
      endcase
    end else if (req_valid_i) begin
      unique case (eff_mode)
        ST_R: begin
          wr_en_o     = 1'b1;
          msg_valid_o = 1'b1;
          if (!req_excl_i) begin
            nxt_mode_o  = ST_R;
            nxt_vec_o   = cur_vec_i | req_oh;
            req_ready_o = 1'b1;
            msg_kind_o  = MSG_SH_REP;
            msg_dest_o  = req_oh;
          end else if (others == '0) begin
            nxt_mode_o  = ST_W;
            nxt_vec_o   = req_oh;
            req_ready_o = 1'b1;
            msg_kind_o  = MSG_EX_REP;
            msg_dest_o  = req_oh;
          end else begin
            nxt_mode_o = ST_TR;
            nxt_vec_o  = others;
            msg_kind_o = MSG_INV_REQ;
            msg_dest_o = others;
          end
        end
        ST_W: begin
          if (cur_vec_i != req_oh) begin
            wr_en_o     = 1'b1;
            nxt_mode_o  = ST_TW;
            msg_valid_o = 1'b1;
            msg_kind_o  = req_excl_i ? MSG_FL_REQ : MSG_WB_REQ;
            msg_dest_o  = cur_vec_i;
          end
        end
        default: ;  // transient: hold the request
      endcase
    end else if (push_valid_i) begin
      if (eff_mode == ST_R && (cur_vec_i & push_oh) == '0) begin
        wr_en_o     = 1'b1;
        nxt_mode_o  = ST_R;
        nxt_vec_o   = cur_vec_i | push_oh;
        msg_valid_o = 1'b1;
        msg_kind_o  = MSG_SH_REP;
        msg_dest_o  = push_oh;
      end
    end
  end
endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
  import coh_pkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int ID_W  = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_excl_i,
  input  logic [ID_W-1:0]   req_id_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  input  logic              rep_valid_i,
  input  logic [1:0]        rep_kind_i,
  input  logic [ID_W-1:0]   rep_id_i,
  input  logic [ADDR_W-1:0] rep_addr_i,
  input  logic [DATA_W-1:0] rep_data_i,
  input  logic              push_valid_i,
  input  logic [ID_W-1:0]   push_id_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  output logic              out_valid_o,
  output logic [2:0]        out_kind_o,
  output logic [N-1:0]      out_dest_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [DATA_W-1:0] out_data_o
);
  logic [ADDR_W-1:0] sel_addr;
  dir_mode_e         cur_mode, nxt_mode;
  logic [N-1:0]      cur_vec, nxt_vec, msg_dest;
  logic [DATA_W-1:0] cur_data, nxt_data;
  logic              wr_en, msg_valid;
  msg_kind_e         msg_kind;

  // reply > request > push on the single table port
  assign sel_addr = rep_valid_i ? rep_addr_i : (req_valid_i ? req_addr_i : push_addr_i);

  dir_table #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_table (
    .clk_i, .rst_ni,
    .addr_i   (sel_addr),
    .wr_en_i  (wr_en),
    .wr_mode_i(nxt_mode),
    .wr_vec_i (nxt_vec),
    .wr_data_i(nxt_data),
    .rd_mode_o(cur_mode),
    .rd_vec_o (cur_vec),
    .rd_data_o(cur_data)
  );

  dir_engine #(.N(N), .DATA_W(DATA_W)) u_engine (
    .rep_valid_i,
    .rep_kind_i  (rep_kind_e'(rep_kind_i)),
    .rep_id_i,
    .rep_data_i,
    .req_valid_i,
    .req_excl_i,
    .req_id_i,
    .push_valid_i,
    .push_id_i,
    .cur_mode_i  (cur_mode),
    .cur_vec_i   (cur_vec),
    .cur_data_i  (cur_data),
    .wr_en_o     (wr_en),
    .nxt_mode_o  (nxt_mode),
    .nxt_vec_o   (nxt_vec),
    .nxt_data_o  (nxt_data),
    .req_ready_o (req_ready_o),
    .msg_valid_o (msg_valid),
    .msg_kind_o  (msg_kind),
    .msg_dest_o  (msg_dest)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_kind_o  <= '0;
      out_dest_o  <= '0;
      out_addr_o  <= '0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= msg_valid;
      if (msg_valid) begin
        out_kind_o <= msg_kind;
        out_dest_o <= msg_dest;
        out_addr_o <= sel_addr;
        out_data_o <= cur_data;
      end
    end
  end
endmodule

// File: rtl/home_dir_ctrl_chk.sv
module home_dir_ctrl_chk #(
  parameter int N = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         req_valid_i,
  input logic         req_ready_o,
  input logic         rep_valid_i,
  input logic         out_valid_o,
  input logic [2:0]   out_kind_o,
  input logic [N-1:0] out_dest_o
);
  // R10
  rep_blocks_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_valid_i |-> !req_ready_o);
  // R10
  rep_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_valid_i |=> !out_valid_o);
  // R2
  deq_replies_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> out_valid_o && (out_kind_o == 3'd0 || out_kind_o == 3'd1));
  // R12
  directed_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_kind_o != 3'd4 |-> $countones(out_dest_o) == 1);
  // R5
  inv_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_kind_o == 3'd4 |-> out_dest_o != '0);
  // R3
  recall_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && (out_kind_o == 3'd2 || out_kind_o == 3'd3)
      |-> $past(req_valid_i && !req_ready_o));
  // R12
  kind_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_kind_o <= 3'd4);
endmodule

bind home_dir_ctrl home_dir_ctrl_chk #(.N(N)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .rep_valid_i(rep_valid_i),
  .out_valid_o(out_valid_o),
  .out_kind_o (out_kind_o),
  .out_dest_o (out_dest_o)
);

// File: tb/home_dir_ctrl_bench.sv
`timescale 1ns/1ps
module home_dir_ctrl_bench;
  localparam int N = 4, ADDR_W = 3, DATA_W = 8, ID_W = 2, DEPTH = 8;
  // bench-side mode codes
  localparam int MR = 0, MW = 1, MTR = 2, MTW = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 0, req_excl_i = 0, rep_valid_i = 0, push_valid_i = 0;
  logic [ID_W-1:0] req_id_i = 0, rep_id_i = 0, push_id_i = 0;
  logic [ADDR_W-1:0] req_addr_i = 0, rep_addr_i = 0, push_addr_i = 0;
  logic [1:0] rep_kind_i = 0;
  logic [DATA_W-1:0] rep_data_i = 0;
  logic req_ready_o, out_valid_o;
  logic [2:0] out_kind_o;
  logic [N-1:0] out_dest_o;
  logic [ADDR_W-1:0] out_addr_o;
  logic [DATA_W-1:0] out_data_o;

  always #10 clk = ~clk;

  home_dir_ctrl #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_home_dir_ctrl (
    .clk_i(clk), .rst_ni, .req_valid_i, .req_excl_i, .req_id_i, .req_addr_i, .req_ready_o,
    .rep_valid_i, .rep_kind_i, .rep_id_i, .rep_addr_i, .rep_data_i,
    .push_valid_i, .push_id_i, .push_addr_i,
    .out_valid_o, .out_kind_o, .out_dest_o, .out_addr_o, .out_data_o);

  int errors = 0, checks = 0;
  int m_mode [DEPTH];
  logic [N-1:0] m_vec [DEPTH];
  logic [DATA_W-1:0] m_data [DEPTH];

  logic e_ready, e_mv;
  logic [2:0] e_kind;
  logic [N-1:0] e_dest;
  logic [ADDR_W-1:0] e_addr;
  logic [DATA_W-1:0] e_data;
  string tag;

  function automatic logic [N-1:0] oh(input logic [ID_W-1:0] id);
    return N'(1) << id;
  endfunction

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  // reference directory model, applied to the stimulus of one cycle
  task automatic model;
    int a, md;
    e_ready = 0; e_mv = 0; e_kind = 0; e_dest = 0; e_addr = 0; e_data = 0; tag = "R12";
    if (rep_valid_i) begin
      a = int'(rep_addr_i);
      tag = "R10";
      if (rep_kind_i == 2'd0 && (m_mode[a] == MR || m_mode[a] == MTR))
        m_vec[a] &= ~oh(rep_id_i);
      else if (rep_kind_i == 2'd1) begin
        m_mode[a] = MR; m_vec[a] = oh(rep_id_i); m_data[a] = rep_data_i;
      end else if (rep_kind_i == 2'd2) begin
        m_mode[a] = MR; m_vec[a] = '0; m_data[a] = rep_data_i;
      end
    end else if (req_valid_i) begin
      a = int'(req_addr_i);
      md = (m_mode[a] == MTR && m_vec[a] == '0) ? MR : m_mode[a];
      e_addr = req_addr_i; e_data = m_data[a];
      if (md == MR && !req_excl_i) begin
        tag = "R2"; e_ready = 1; e_mv = 1; e_kind = 0; e_dest = oh(req_id_i);
        m_mode[a] = MR; m_vec[a] |= oh(req_id_i);
      end else if (md == MR && (m_vec[a] & ~oh(req_id_i)) == '0) begin
        tag = (m_mode[a] == MTR) ? "R8" : "R4";
        e_ready = 1; e_mv = 1; e_kind = 1; e_dest = oh(req_id_i);
        m_mode[a] = MW; m_vec[a] = oh(req_id_i);
      end else if (md == MR) begin
        tag = "R5"; e_mv = 1; e_kind = 4; e_dest = m_vec[a] & ~oh(req_id_i);
        m_mode[a] = MTR; m_vec[a] = e_dest;
      end else if (md == MW && m_vec[a] != oh(req_id_i)) begin
        tag = req_excl_i ? "R6" : "R3";
        e_mv = 1; e_kind = req_excl_i ? 3'd3 : 3'd2; e_dest = m_vec[a];
        m_mode[a] = MTW;
      end else tag = "R7";
    end else if (push_valid_i) begin
      a = int'(push_addr_i);
      md = (m_mode[a] == MTR && m_vec[a] == '0) ? MR : m_mode[a];
      tag = "R11";
      if (md == MR && (m_vec[a] & oh(push_id_i)) == '0) begin
        e_mv = 1; e_kind = 0; e_dest = oh(push_id_i); e_addr = push_addr_i; e_data = m_data[a];
        m_mode[a] = MR; m_vec[a] |= oh(push_id_i);
      end
    end
  endtask

  task automatic step(input logic rv, input logic [1:0] rk, input logic [ID_W-1:0] rid,
                      input logic [ADDR_W-1:0] ra, input logic [DATA_W-1:0] rd,
                      input logic qv, input logic qx, input logic [ID_W-1:0] qid,
                      input logic [ADDR_W-1:0] qa,
                      input logic pv, input logic [ID_W-1:0] pid, input logic [ADDR_W-1:0] pa,
                      output logic deq);
    @(negedge clk);
    rep_valid_i = rv; rep_kind_i = rk; rep_id_i = rid; rep_addr_i = ra; rep_data_i = rd;
    req_valid_i = qv; req_excl_i = qx; req_id_i = qid; req_addr_i = qa;
    push_valid_i = pv; push_id_i = pid; push_addr_i = pa;
    model();
    #1;
    chk({tag, " ready"}, 32'(req_ready_o), 32'(e_ready));
    deq = req_ready_o;
    @(posedge clk); #1;
    chk({tag, " out_valid"}, 32'(out_valid_o), 32'(e_mv));
    if (e_mv && out_valid_o) begin
      chk({tag, " kind"}, 32'(out_kind_o), 32'(e_kind));
      chk({tag, " dest"}, 32'(out_dest_o), 32'(e_dest));
      chk({tag, " addr"}, 32'(out_addr_o), 32'(e_addr));
      chk({tag, " data"}, 32'(out_data_o), 32'(e_data));
    end
  endtask

  // shorthands
  task automatic rq(input logic x, input int id, input int a);
    logic d;
    step(0, 0, 0, 0, 0, 1, x, ID_W'(id), ADDR_W'(a), 0, 0, 0, d);
  endtask
  task automatic rp(input int k, input int id, input int a, input int v);
    logic d;
    step(1, 2'(k), ID_W'(id), ADDR_W'(a), DATA_W'(v), 0, 0, 0, 0, 0, 0, 0, d);
  endtask
  task automatic ps(input int id, input int a);
    logic d;
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, ID_W'(id), ADDR_W'(a), d);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic d;
    for (int i = 0; i < DEPTH; i++) begin m_mode[i] = MR; m_vec[i] = '0; m_data[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R1 out_valid at reset", 32'(out_valid_o), 0);
    rst_ni = 1'b1;

    // R1: fresh line reads zero data, empty set
    rq(0, 0, 5);              // R2 shared, data 0
    rq(1, 1, 5);              // R5 invalidate to cache 0
    rq(1, 1, 5);              // R7 held
    step(1, 0, 0, 5, 0, 1, 1, 1, 5, 0, 0, 0, d); // R10 reply beats request, R8 removes 0
    rq(1, 1, 5);              // R8 drained -> exclusive reply
    rq(0, 1, 5);              // R7 owner asks itself
    rq(0, 2, 5);              // R3 writeback request to cache 1
    rq(0, 2, 5);              // R7 held in recall
    rp(1, 1, 5, 8'hA5);       // R9 writeback -> R({1})
    rq(0, 2, 5);              // R2 data A5
    ps(3, 5);                 // R11 push accepted
    ps(3, 5);                 // R11 push ignored (member)
    rq(1, 3, 5);              // R5 mask {1,2}
    ps(0, 5);                 // R11 ignored in transient readers
    rp(0, 1, 5, 0);
    rp(0, 2, 5, 0);
    rq(1, 3, 5);              // R8 exclusive reply
    rq(1, 0, 5);              // R6 flush request to cache 3
    rp(2, 3, 5, 8'h3C);       // R9 flush -> R(empty)
    rq(1, 0, 5);              // R4 exclusive, data 3C
    rq(1, 0, 2);              // R4 empty set
    step(0, 0, 0, 0, 0, 1, 0, 1, 2, 1, 2, 3, d); // R11 push not taken with request

    // random phase
    begin
      logic hv = 0, hx = 0;
      logic [ID_W-1:0] hid = 0;
      logic [ADDR_W-1:0] ha = 0;
      void'($urandom(32'h5eed));
      for (int i = 0; i < 4000; i++) begin
        int r = int'($urandom % 10);
        int a = int'(ha);
        if (hv && r < 4) begin
          int k = 0, id = 0;
          if (m_mode[a] == MTR) begin
            for (int b = N - 1; b >= 0; b--) if (m_vec[a][b]) id = b;
            k = 0;
          end else if (m_mode[a] == MTW || m_mode[a] == MW) begin
            for (int b = 0; b < N; b++) if (m_vec[a][b]) id = b;
            k = 1 + int'($urandom % 2);
          end else begin
            id = int'($urandom % N);
          end
          step(1, 2'(k), ID_W'(id), ha, DATA_W'($urandom), 0, 0, 0, 0, 0, 0, 0, d);
        end else if (r < 5) begin
          step(1, 2'($urandom % 3), ID_W'($urandom), ADDR_W'($urandom), DATA_W'($urandom),
               hv, hx, hid, ha, 0, 0, 0, d);
        end else if (r == 9 && !hv) begin
          ps(int'($urandom % N), int'($urandom % DEPTH));
        end else begin
          if (!hv) begin
            hv = 1; hx = 1'($urandom); hid = ID_W'($urandom); ha = ADDR_W'($urandom);
          end
          step(0, 0, 0, 0, 0, hv, hx, hid, ha, 1'($urandom), ID_W'($urandom),
               ADDR_W'($urandom), d);
          if (d) hv = 0;
        end
      end
    end
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule